// File: doc/BRIEF.md
# Four-Sample 9/7 Forward Lifting Unit

This block computes one level of the forward 1-D biorthogonal 9/7 wavelet transform along a row. Each clock it takes four consecutive samples of the row, two even and two odd, and it produces two high-pass and two low-pass coefficients. The two lifting steps are merged so that the low-pass path is carried divided by beta from the input up to the scaling stage. The even samples are therefore pre-multiplied by 1/beta, and the second update uses delta/beta as its weight. A final stage applies 1/k to the high-pass band and k·beta to the low-pass band.

Each lifting equation needs values from the neighbouring group. The unit therefore keeps the last sample, predict and update values of each group in registers and finishes group g when group g+1 arrives. At the end of a row it inserts one internal flush slot, which uses symmetric extension. At the start of a row, symmetric extension replaces the missing left neighbours. A caller streams rows with `in_valid` and `in_last` and collects results with `out_valid` and `out_last`.

Top module: `dwt97_quad`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_last` are low and all four coefficient outputs are zero.
- R2: Lane mapping: for group g, `in_x0..in_x3` carry samples x[4g], x[4g+1], x[4g+2], x[4g+3] as signed integers. Each sample enters the datapath shifted left by FB fraction bits (default 5). `out_hi0/out_lo0` carry coefficient index 2g and `out_hi1/out_lo1` carry index 2g+1. Every output is a signed 32-bit value with FB fraction bits.
- R3: Step one, with s0[i]=x[2i] and d0[i]=x[2i+1]: p[i] = d0[i] + mul(s0[i]+s0[i+1], alpha). The update kept over beta is u[i] = mul(s0[i], 1/beta) + p[i-1] + p[i].
- R4: Step two: q[i] = p[i] + mul(u[i]+u[i+1], beta·gamma). The low path is w[i] = u[i] + mul(q[i-1]+q[i], delta/beta).
- R5: The outputs are hi[i] = mul(q[i], 1/k) and lo[i] = mul(w[i], k·beta). The constants are alpha=-1.586134342, beta=-0.052980118, gamma=0.882911076, delta=0.443506852 and k=1.149604398. Each constant c is held as round-half-away-from-zero(c·2^12). mul(a,c) is the exact product shifted right arithmetically by 12.
- R6: Left edge: p[-1] is taken as p[0] and q[-1] is taken as q[0].
- R7: Right edge, with M even samples in the row: s0[M] is taken as s0[M-1] and u[M] is taken as u[M-1].
- R8: The coefficients of a group that is not the last of its row are loaded into the output registers on the second rising edge after the edge that accepts the next group of the row. The last group's coefficients are loaded on the third rising edge after its own acceptance.
- R9: The cycle after a group with `in_last` must have `in_valid` low, because the unit uses it to finish the row. The first group of a row produces no output on its own. `out_last` is high exactly with the coefficients of the row's last group.
- R10: Idle cycles between the groups of a row do not change any coefficient.
- R11: A row of exactly four samples (one group) is transformed correctly, with both edge rules applied.
- R12: The coefficients of a row do not depend on any row that came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group of four samples present |
| in_last | input | 1 | Present group is the last of its row |
| in_x0 | input | DW (16) | Sample x[4g] (even) |
| in_x1 | input | DW (16) | Sample x[4g+1] (odd) |
| in_x2 | input | DW (16) | Sample x[4g+2] (even) |
| in_x3 | input | DW (16) | Sample x[4g+3] (odd) |
| out_valid | output | 1 | Coefficient pair present |
| out_last | output | 1 | Pair belongs to the last group of the row |
| out_hi0 | output | IW (32) | High-pass coefficient, index 2g |
| out_lo0 | output | IW (32) | Low-pass coefficient, index 2g |
| out_hi1 | output | IW (32) | High-pass coefficient, index 2g+1 |
| out_lo1 | output | IW (32) | Low-pass coefficient, index 2g+1 |

## Verification
The unit is driven with several kinds of row, and each kind shows up a different class of error:
- A single impulse places a nonzero value in exactly one term of each equation, so a wrong constant or a swapped lane shows up in isolation.
- A linear ramp makes the interior high-pass band nearly vanish, so any asymmetric error at the row edges stands out.
- A constant row tests the low-pass gain.
- Pseudo-random rows mix every term.
- A one-group row exercises both edge rules together.
- A row with idle cycles between groups confirms that the carried neighbours are held.
- An impulse row sent after a random row must give the same result as sent after reset, which shows that the row boundary clears all carried state.
- A three-group row checked cycle by cycle fixes the output timing and the position of `out_last`.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

  // 9/7 lifting constants
  localparam real ALPHA = -1.586134342;
  localparam real BETA  = -0.052980118;
  localparam real GAMMA =  0.882911076;
  localparam real DELTA =  0.443506852;
  localparam real KSCL  =  1.149604398;

  // Quantize a real constant to frac fraction bits, half away from zero
  function automatic int qcoef(input real c, input int frac);
    real scaled;
    scaled = c * (2.0 ** frac);
    return $rtoi(scaled + ((scaled < 0.0) ? -0.5 : 0.5));
  endfunction

endpackage

// File: rtl/dwt97_cmul.sv
// Constant multiplier: exact product, arithmetic shift right by CF
module dwt97_cmul #(
  parameter int IW   = 32,
  parameter int CW   = 20,
  parameter int CF   = 12,
  parameter int COEF = 0
) (
  input  logic signed [IW-1:0] a,
  output logic signed [IW-1:0] p
);
  localparam logic signed [CW-1:0] KQ = CW'(COEF);

  logic signed [IW+CW-1:0] full;

  assign full = a * KQ;
  assign p    = IW'(full >>> CF);
endmodule

// File: rtl/dwt97_step1.sv
// Predict 1 merged with update 1; the update result is kept divided by beta.
// Slot g handles indices 2g-1 (carried) and 2g (new group).
module dwt97_step1 #(
  parameter int IW = 32,
  parameter int CW = 20,
  parameter int CF = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 first,
  input  logic                 flush,
  input  logic signed [IW-1:0] e0,
  input  logic signed [IW-1:0] o0,
  input  logic signed [IW-1:0] e1,
  input  logic signed [IW-1:0] o1,
  output logic                 q_valid,
  output logic                 q_first,
  output logic                 q_flush,
  output logic signed [IW-1:0] q_da,
  output logic signed [IW-1:0] q_db,
  output logic signed [IW-1:0] q_ua,
  output logic signed [IW-1:0] q_ub
);
  localparam int K_ALPHA = dwt97_pkg::qcoef(dwt97_pkg::ALPHA, CF);
  localparam int K_INVB  = dwt97_pkg::qcoef(1.0 / dwt97_pkg::BETA, CF);

  logic signed [IW-1:0] hs, hd, hd1;            // carried s0, d0, p
  logic signed [IW-1:0] se0, sum_a, sum_b;
  logic signed [IW-1:0] ma, mb, mia, mib;
  logic signed [IW-1:0] d1a, d1b;

  assign se0   = flush ? hs : e0;               // right edge mirror
  assign sum_a = hs + se0;
  assign sum_b = se0 + e1;

  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_ALPHA)) u_ma  (.a(sum_a), .p(ma));
  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_ALPHA)) u_mb  (.a(sum_b), .p(mb));
  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_INVB))  u_mia (.a(hs),    .p(mia));
  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_INVB))  u_mib (.a(se0),   .p(mib));

  assign d1b = o0 + mb;
  assign d1a = first ? d1b : (hd + ma);         // left edge mirror

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_first <= 1'b0;
      q_flush <= 1'b0;
      q_da    <= '0;
      q_db    <= '0;
      q_ua    <= '0;
      q_ub    <= '0;
      hs      <= '0;
      hd      <= '0;
      hd1     <= '0;
    end else begin
      q_valid <= adv;
      if (adv) begin
        q_first <= first;
        q_flush <= flush;
        q_da    <= d1a;
        q_db    <= d1b;
        q_ua    <= mia + hd1 + d1a;
        q_ub    <= mib + d1a + d1b;
        hs      <= e1;
        hd      <= o1;
        hd1     <= d1b;
      end
    end
  end

  AST_FIRST_FLUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(first && flush)); // R9
endmodule

// File: rtl/dwt97_step2.sv
// Predict 2 merged with update 2 (low path still over beta).
// Slot g emits indices 2g-2 and 2g-1.
module dwt97_step2 #(
  parameter int IW = 32,
  parameter int CW = 20,
  parameter int CF = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_flush,
  input  logic signed [IW-1:0] da,
  input  logic signed [IW-1:0] db,
  input  logic signed [IW-1:0] ua,
  input  logic signed [IW-1:0] ub,
  output logic                 q_valid,
  output logic                 q_last,
  output logic signed [IW-1:0] q_h0,
  output logic signed [IW-1:0] q_l0,
  output logic signed [IW-1:0] q_h1,
  output logic signed [IW-1:0] q_l1
);
  localparam int K_BG = dwt97_pkg::qcoef(dwt97_pkg::BETA * dwt97_pkg::GAMMA, CF);
  localparam int K_DB = dwt97_pkg::qcoef(dwt97_pkg::DELTA / dwt97_pkg::BETA, CF);

  logic signed [IW-1:0] hu, hq, hd2;
  logic                 after_first;
  logic signed [IW-1:0] ube, mx, my, d2x, d2y, prev2, nx, ny;

  assign ube = in_flush ? ua : ub;              // right edge mirror

  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_BG)) u_mx (.a(hu + ua),  .p(mx));
  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_BG)) u_my (.a(ua + ube), .p(my));

  assign d2x   = hq + mx;
  assign d2y   = da + my;
  assign prev2 = after_first ? d2x : hd2;       // left edge mirror

  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_DB)) u_nx (.a(prev2 + d2x), .p(nx));
  dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_DB)) u_ny (.a(d2x + d2y),   .p(ny));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid     <= 1'b0;
      q_last      <= 1'b0;
      q_h0        <= '0;
      q_l0        <= '0;
      q_h1        <= '0;
      q_l1        <= '0;
      hu          <= '0;
      hq          <= '0;
      hd2         <= '0;
      after_first <= 1'b0;
    end else begin
      q_valid <= in_valid && !in_first;
      q_last  <= in_valid && in_flush;
      if (in_valid) begin
        q_h0        <= d2x;
        q_l0        <= hu + nx;
        q_h1        <= d2y;
        q_l1        <= ua + ny;
        hu          <= ub;
        hq          <= db;
        hd2         <= d2y;
        after_first <= in_first;
      end
    end
  end
endmodule

// File: rtl/dwt97_scale.sv
// Final band scaling, one lane pair per generate instance
module dwt97_scale #(
  parameter int IW    = 32,
  parameter int CW    = 20,
  parameter int CF    = 12,
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic signed [IW-1:0] hi_in [LANES],
  input  logic signed [IW-1:0] lo_in [LANES],
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [IW-1:0] hi_out [LANES],
  output logic signed [IW-1:0] lo_out [LANES]
);
  localparam int K_INVK = dwt97_pkg::qcoef(1.0 / dwt97_pkg::KSCL, CF);
  localparam int K_KB   = dwt97_pkg::qcoef(dwt97_pkg::KSCL * dwt97_pkg::BETA, CF);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid && in_last;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [IW-1:0] hs, ls;
    dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_INVK)) u_h (.a(hi_in[l]), .p(hs));
    dwt97_cmul #(.IW(IW), .CW(CW), .CF(CF), .COEF(K_KB))   u_l (.a(lo_in[l]), .p(ls));
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_out[l] <= '0;
        lo_out[l] <= '0;
      end else if (in_valid) begin
        hi_out[l] <= hs;
        lo_out[l] <= ls;
      end
    end
  end
endmodule

// File: rtl/dwt97_quad.sv
module dwt97_quad #(
  parameter  int DW = 16,
  parameter  int FB = 5,
  parameter  int CF = 12,
  parameter  int CW = 20,
  localparam int IW = DW + FB + 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_last,
  input  logic signed [DW-1:0] in_x0,
  input  logic signed [DW-1:0] in_x1,
  input  logic signed [DW-1:0] in_x2,
  input  logic signed [DW-1:0] in_x3,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [IW-1:0] out_hi0,
  output logic signed [IW-1:0] out_lo0,
  output logic signed [IW-1:0] out_hi1,
  output logic signed [IW-1:0] out_lo1
);
  logic flush_req, row_start, adv, first;
  logic signed [IW-1:0] xw0, xw1, xw2, xw3;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req <= 1'b0;
      row_start <= 1'b1;
    end else begin
      flush_req <= in_valid && in_last;
      if (flush_req)     row_start <= 1'b1;
      else if (in_valid) row_start <= 1'b0;
    end
  end

  assign adv   = in_valid || flush_req;
  assign first = in_valid && row_start;

  assign xw0 = (IW'(in_x0)) <<< FB;
  assign xw1 = (IW'(in_x1)) <<< FB;
  assign xw2 = (IW'(in_x2)) <<< FB;
  assign xw3 = (IW'(in_x3)) <<< FB;

  logic                 s1_valid, s1_first, s1_flush;
  logic signed [IW-1:0] s1_da, s1_db, s1_ua, s1_ub;

  dwt97_step1 #(.IW(IW), .CW(CW), .CF(CF)) u_step1 (
    .clk(clk), .rst(rst), .adv(adv), .first(first), .flush(flush_req),
    .e0(xw0), .o0(xw1), .e1(xw2), .o1(xw3),
    .q_valid(s1_valid), .q_first(s1_first), .q_flush(s1_flush),
    .q_da(s1_da), .q_db(s1_db), .q_ua(s1_ua), .q_ub(s1_ub)
  );

  logic                 s2_valid, s2_last;
  logic signed [IW-1:0] s2_hi [2];
  logic signed [IW-1:0] s2_lo [2];

  dwt97_step2 #(.IW(IW), .CW(CW), .CF(CF)) u_step2 (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_first(s1_first), .in_flush(s1_flush),
    .da(s1_da), .db(s1_db), .ua(s1_ua), .ub(s1_ub),
    .q_valid(s2_valid), .q_last(s2_last),
    .q_h0(s2_hi[0]), .q_l0(s2_lo[0]), .q_h1(s2_hi[1]), .q_l1(s2_lo[1])
  );

  logic signed [IW-1:0] sc_hi [2];
  logic signed [IW-1:0] sc_lo [2];

  dwt97_scale #(.IW(IW), .CW(CW), .CF(CF), .LANES(2)) u_scale (
    .clk(clk), .rst(rst), .in_valid(s2_valid), .in_last(s2_last),
    .hi_in(s2_hi), .lo_in(s2_lo),
    .out_valid(out_valid), .out_last(out_last),
    .hi_out(sc_hi), .lo_out(sc_lo)
  );

  assign out_hi0 = sc_hi[0];
  assign out_lo0 = sc_lo[0];
  assign out_hi1 = sc_hi[1];
  assign out_lo1 = sc_lo[1];

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> !in_valid); // R9
  AST_LAST_TIMING: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> ##3 (out_valid && out_last)); // R8
  AST_NONLAST_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> $past(in_valid, 3)); // R8
  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && row_start) |=> ##2 !out_valid); // R9
endmodule

// File: tb/dwt97_quad_tb.sv
`timescale 1ns/1ps
module dwt97_quad_tb;
  localparam int FB = 5;
  localparam int CF = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic signed [15:0] in_x0 = '0, in_x1 = '0, in_x2 = '0, in_x3 = '0;
  logic out_valid, out_last;
  logic signed [31:0] out_hi0, out_lo0, out_hi1, out_lo1;

  always #2 clk = ~clk;

  dwt97_quad u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2), .in_x3(in_x3),
    .out_valid(out_valid), .out_last(out_last),
    .out_hi0(out_hi0), .out_lo0(out_lo0), .out_hi1(out_hi1), .out_lo1(out_lo1)
  );

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    longint h0, l0, h1, l1;
    bit     last;
  } exp_t;
  exp_t  expq [$];
  string tagq [$];

  longint rb [0:63];
  int unsigned seed = 32'h1234_5678;

  function automatic longint qc(input real c);
    real s;
    s = c * 4096.0;
    return longint'($rtoi(s + ((s < 0.0) ? -0.5 : 0.5)));
  endfunction

  longint QA, QIB, QBG, QDB, QIK, QKB;
  initial begin
    QA  = qc(-1.586134342);
    QIB = qc(1.0 / -0.052980118);
    QBG = qc(-0.052980118 * 0.882911076);
    QDB = qc(0.443506852 / -0.052980118);
    QIK = qc(1.0 / 1.149604398);
    QKB = qc(1.149604398 * -0.052980118);
  end

  function automatic longint mq(input longint a, input longint c);
    return (a * c) >>> CF;
  endfunction

  // Reference model on whole arrays with mirrored edges
  task automatic model_push(input int n, input string tag);
    longint s0 [32], d0 [32], p [32], u [32], q [32], w [32];
    int m;
    m = n / 2;
    for (int i = 0; i < m; i++) begin
      s0[i] = rb[2*i] * (longint'(1) << FB);
      d0[i] = rb[2*i+1] * (longint'(1) << FB);
    end
    for (int i = 0; i < m; i++)
      p[i] = d0[i] + mq(s0[i] + ((i + 1 < m) ? s0[i+1] : s0[m-1]), QA);
    for (int i = 0; i < m; i++)
      u[i] = mq(s0[i], QIB) + ((i > 0) ? p[i-1] : p[0]) + p[i];
    for (int i = 0; i < m; i++)
      q[i] = p[i] + mq(u[i] + ((i + 1 < m) ? u[i+1] : u[m-1]), QBG);
    for (int i = 0; i < m; i++)
      w[i] = u[i] + mq(((i > 0) ? q[i-1] : q[0]) + q[i], QDB);
    for (int g = 0; g < n / 4; g++) begin
      exp_t e;
      e.h0   = mq(q[2*g], QIK);
      e.l0   = mq(w[2*g], QKB);
      e.h1   = mq(q[2*g+1], QIK);
      e.l1   = mq(w[2*g+1], QKB);
      e.last = (g == n / 4 - 1);
      expq.push_back(e);
      tagq.push_back(tag);
    end
  endtask

  task automatic drive_group(input int g, input bit last);
    in_valid = 1'b1;
    in_last  = last;
    in_x0 = 16'(rb[4*g]);
    in_x1 = 16'(rb[4*g+1]);
    in_x2 = 16'(rb[4*g+2]);
    in_x3 = 16'(rb[4*g+3]);
  endtask

  task automatic go_idle();
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_row(input int n, input int gap, input string tag);
    model_push(n, tag);
    for (int g = 0; g < n / 4; g++) begin
      @(negedge clk);
      drive_group(g, g == n / 4 - 1);
      if (g != n / 4 - 1) begin
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          go_idle();
        end
      end
    end
    @(negedge clk);
    go_idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd_sample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'((seed >> 16) % 2001) - 1000;
  endfunction

  // Monitor: compare every produced pair with the queue head
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected output", 1, 0);
      end else begin
        exp_t  e;
        string t;
        bit    ok;
        e = expq.pop_front();
        t = tagq.pop_front();
        ok = (longint'(out_hi0) == e.h0) && (longint'(out_lo0) == e.l0) &&
             (longint'(out_hi1) == e.h1) && (longint'(out_lo1) == e.l1) &&
             (out_last == e.last);
        if (!ok)
          $display("FAIL %s hi0/lo0/hi1/lo1/last actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
                   t, out_hi0, out_lo0, out_hi1, out_lo1, out_last,
                   e.h0, e.l0, e.h1, e.l1, e.last);
        total++;
        if (!ok) bad++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_last == 1'b0, "R1 flags after reset", out_valid, 0);
    check(out_hi0 == 0 && out_lo0 == 0 && out_hi1 == 0 && out_lo1 == 0,
          "R1 data after reset", longint'(out_hi0), 0);

    // Impulse: R2 R3 R4 R5 lane mapping and constants
    for (int i = 0; i < 16; i++) rb[i] = 0;
    rb[5] = 100;
    run_row(16, 0, "R2 R3 R4 R5 impulse");

    // Ramp: R6 R7 mirrored edges
    for (int i = 0; i < 16; i++) rb[i] = 10 * i - 70;
    run_row(16, 0, "R6 R7 ramp");

    // Constant: R5 low-pass gain
    for (int i = 0; i < 8; i++) rb[i] = 300;
    run_row(8, 0, "R5 constant");

    // Pseudo-random: R3 R4
    for (int i = 0; i < 32; i++) rb[i] = rnd_sample();
    run_row(32, 0, "R3 R4 random");

    // Single group: R11
    rb[0] = 50; rb[1] = -20; rb[2] = 80; rb[3] = 7;
    run_row(4, 0, "R11 one group");

    // Gaps inside a row: R10
    for (int i = 0; i < 16; i++) rb[i] = rnd_sample();
    run_row(16, 2, "R10 gapped");

    // Impulse after unrelated row: R12
    for (int i = 0; i < 16; i++) rb[i] = 0;
    rb[5] = 100;
    run_row(16, 0, "R12 impulse after random");

    // Cycle-exact timing: R8 R9 on a three-group row
    for (int i = 0; i < 12; i++) rb[i] = rnd_sample();
    model_push(12, "R8 timed row");
    @(negedge clk); drive_group(0, 1'b0);
    @(negedge clk); drive_group(1, 1'b0);
    @(negedge clk); drive_group(2, 1'b1);
    @(negedge clk); go_idle();
    check(out_valid == 1'b0, "R9 first group silent", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_last == 1'b0, "R8 group0 timing", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b1 && out_last == 1'b0, "R8 group1 timing", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b1 && out_last == 1'b1, "R8 R9 last group timing", out_last, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle after row", out_valid, 0);

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R9 all expected pairs produced", expq.size(), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule